// File: doc/BRIEF.md
# Triple 24-bit Event Timer

This block holds three identical 24-bit timer channels and one shared 21-bit prescaler. A host programs it through a small synchronous register bus. Each channel has a control/status word, a compare register and a counter. A channel counts either on every clock or on each tick of the shared prescaler. A tick occurs when the prescaler reaches a programmable terminal value and restarts from zero.

Each channel raises a flag and, if enabled, an interrupt request when its counter wraps from all-ones to zero. In compare mode it raises a second flag, optionally with an interrupt, when the counter steps onto the compare value. On each such match it also toggles its timer pin.

Each channel's sequencing is a two-state machine. `CH_OFF` leaves the counter frozen. The *start* transition to `CH_RUN` is taken on a control write with the enable bit set, and it clears the counter. In `CH_RUN` the counter advances on each count event. The *stop* transition back to `CH_OFF` is taken on a control write with the enable bit clear. The pins drive only while at least one channel runs; otherwise all output enables drop so the pads float.

Top module: `tmr_triple`

## Requirements
- R1: After reset every control word, counter, prescaler value, read word, interrupt request and pin output-enable is 0.
- R2: A control write with enable (bit 0) set clears the counter only if the channel was stopped. It then advances once per clock while bit 3 is 0. The same write to a running channel leaves the count going.
- R3: A control write with bit 0 clear stops the channel. The count still advances on the edge that takes that write, then holds.
- R4: With bit 3 set, a channel advances once per prescaler tick. The prescaler counts 0 up to its terminal value (address 0xC, writing it restarts the count at 0), then ticks and restarts. Its live value reads at address 0xD.
- R5: A count event at 0xFFFFFF wraps to 0 and sets the overflow flag (bit 12). The channel's overflow request is high while that flag and bit 1 are both set.
- R6: With mode field bits 7:4 = 1, a count event that brings the counter to the compare value sets the compare flag (bit 13) and toggles the channel pin. The compare request is high while that flag and bit 2 are set.
- R7: Writing 1 to bit 12 or 13 clears that flag. A flag being set on the same edge stays set.
- R8: Control bits 8-11 and 14-23, prescaler bits 23-21, and addresses 0x3, 0x7, 0xB, 0xE, 0xF read 0 and ignore writes. Address map: channel n at 4n+0 control, 4n+1 compare, 4n+2 counter (writable).
- R9: All three pin output-enables are low when no channel runs, and all high when any runs.
- R10: Read data appears one cycle after the address and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wr | input | 1 | Write strobe |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Registered read data |
| irq_ovf | output | 3 | Per-channel overflow request |
| irq_cmp | output | 3 | Per-channel compare request |
| tio | output | 3 | Per-channel timer pin value |
| tio_oe | output | 3 | Per-channel pin output enable |

## Verification
The bench builds the block with its defaults: three channels, 24-bit counters and a 21-bit prescaler. Wrap-around is reached in a few cycles by loading the counter near 0xFFFFFF. Programming a terminal value of 4 makes the prescaler division visible within a dozen clocks. Reloading the counter just below the compare value lines a match up with a flag-clearing write, which exercises the set-over-clear rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_t;

    typedef enum logic [1:0] {
        RG_CTL  = 2'd0,
        RG_CMP  = 2'd1,
        RG_CNT  = 2'd2,
        RG_NONE = 2'd3
    } reg_sel_t;

    localparam int B_EN    = 0;
    localparam int B_OVIE  = 1;
    localparam int B_CMPIE = 2;
    localparam int B_SRC   = 3;
    localparam int B_MODE  = 4;
    localparam int MODE_W  = 4;
    localparam int B_OVF   = 12;
    localparam int B_CMPF  = 13;

    localparam logic [MODE_W-1:0] MODE_FREE = 4'd0;
    localparam logic [MODE_W-1:0] MODE_CMP  = 4'd1;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_wr,
    input  logic [PW-1:0] pre_wdata,
    output logic [PW-1:0] pre_q,
    output logic [PW-1:0] pcnt_q,
    output logic          tick
);

    assign tick = (pcnt_q == pre_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            pcnt_q <= '0;
        end else if (pre_wr) begin
            pre_q  <= pre_wdata;
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= pre_q); // R4
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt_q == '0)); // R4

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 24,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptick,
    input  logic          wr_ctl,
    input  logic          wr_cmp,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctl_rd,
    output logic [CW-1:0] cmp_q,
    output logic [CW-1:0] cnt_q,
    output logic          running,
    output logic          pin_q,
    output logic          irq_ovf,
    output logic          irq_cmp
);

    ch_state_t         st, st_nxt;
    logic              ovie_q, cmpie_q, src_q;
    logic [MODE_W-1:0] mode_q;
    logic              ovf_q, cmpf_q;
    logic              start, adv, wrap, match, ovf_set;
    logic [CW-1:0]     cnt_inc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_OFF;
        else        st <= st_nxt;
    end

    // next state: start / stop
    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_OFF: if (wr_ctl && wdata[B_EN])  st_nxt = CH_RUN;
            CH_RUN: if (wr_ctl && !wdata[B_EN]) st_nxt = CH_OFF;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        start   = (st == CH_OFF) && wr_ctl && wdata[B_EN];
        running = (st == CH_RUN);
        adv     = running && (src_q ? ptick : 1'b1);
        cnt_inc = cnt_q + 1'b1;
        wrap    = (cnt_q == '1);
        ovf_set = adv && !wr_cnt && wrap;
        match   = (mode_q == MODE_CMP) && adv && !wr_cnt && (cnt_inc == cmp_q);
        irq_ovf = ovf_q && ovie_q;
        irq_cmp = cmpf_q && cmpie_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata[CW-1:0];
        end else if (adv) begin
            cnt_q <= cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovie_q  <= 1'b0;
            cmpie_q <= 1'b0;
            src_q   <= 1'b0;
            mode_q  <= MODE_FREE;
            cmp_q   <= '0;
        end else begin
            if (wr_ctl) begin
                ovie_q  <= wdata[B_OVIE];
                cmpie_q <= wdata[B_CMPIE];
                src_q   <= wdata[B_SRC];
                mode_q  <= wdata[B_MODE +: MODE_W];
            end
            if (wr_cmp) cmp_q <= wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            cmpf_q <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            ovf_q  <= ovf_set | (ovf_q  & ~(wr_ctl & wdata[B_OVF]));
            cmpf_q <= match   | (cmpf_q & ~(wr_ctl & wdata[B_CMPF]));
            if (match) pin_q <= ~pin_q;
        end
    end

    always_comb begin
        ctl_rd                  = '0;
        ctl_rd[B_EN]            = running;
        ctl_rd[B_OVIE]          = ovie_q;
        ctl_rd[B_CMPIE]         = cmpie_q;
        ctl_rd[B_SRC]           = src_q;
        ctl_rd[B_MODE +: MODE_W] = mode_q;
        ctl_rd[B_OVF]           = ovf_q;
        ctl_rd[B_CMPF]          = cmpf_q;
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_OFF && wr_ctl && wdata[B_EN]) |=> (cnt_q == '0 && st == CH_RUN)); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_OFF && !wr_ctl && !wr_cnt) |=> $stable(cnt_q)); // R3
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN && adv && !wr_cnt && cnt_q == '1) |=> (cnt_q == '0 && ovf_q)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !wr_ctl) |=> ovf_q); // R7

endmodule

// File: rtl/tmr_triple.sv
module tmr_triple
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 24,
    parameter int PW  = 21,
    parameter int DW  = 24,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic           wr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] irq_ovf,
    output logic [NCH-1:0] irq_cmp,
    output logic [NCH-1:0] tio,
    output logic [NCH-1:0] tio_oe
);

    localparam int IW = AW - 2;

    logic [IW-1:0] idx;
    reg_sel_t      sel;
    logic          tick;
    logic [PW-1:0] pre_q, pcnt_q;
    logic [DW-1:0] ctl_rd [NCH];
    logic [CW-1:0] cmp_q  [NCH];
    logic [CW-1:0] cnt_q  [NCH];
    logic [NCH-1:0] run;
    logic [DW-1:0] rd_nxt;

    assign idx = addr[AW-1:2];
    assign sel = reg_sel_t'(addr[1:0]);

    tmr_prescaler #(.PW(PW)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_wr    (wr && idx == IW'(NCH) && sel == RG_CTL),
        .pre_wdata (wdata[PW-1:0]),
        .pre_q     (pre_q),
        .pcnt_q    (pcnt_q),
        .tick      (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.CW(CW), .DW(DW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ptick   (tick),
            .wr_ctl  (wr && idx == IW'(g) && sel == RG_CTL),
            .wr_cmp  (wr && idx == IW'(g) && sel == RG_CMP),
            .wr_cnt  (wr && idx == IW'(g) && sel == RG_CNT),
            .wdata   (wdata),
            .ctl_rd  (ctl_rd[g]),
            .cmp_q   (cmp_q[g]),
            .cnt_q   (cnt_q[g]),
            .running (run[g]),
            .pin_q   (tio[g]),
            .irq_ovf (irq_ovf[g]),
            .irq_cmp (irq_cmp[g])
        );
    end

    assign tio_oe = {NCH{|run}};

    always_comb begin
        rd_nxt = '0;
        for (int i = 0; i < NCH; i++) begin
            if (idx == IW'(i)) begin
                unique case (sel)
                    RG_CTL:  rd_nxt = ctl_rd[i];
                    RG_CMP:  rd_nxt = DW'(cmp_q[i]);
                    RG_CNT:  rd_nxt = DW'(cnt_q[i]);
                    RG_NONE: rd_nxt = '0;
                endcase
            end
        end
        if (idx == IW'(NCH)) begin
            if (sel == RG_CTL)      rd_nxt = DW'(pre_q);
            else if (sel == RG_CMP) rd_nxt = DW'(pcnt_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_nxt;
    end

endmodule

// File: tb/tmr_triple_test.sv
module tmr_triple_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        wr;
    logic [23:0] wdata;
    logic [23:0] rdata;
    logic [2:0]  irq_ovf, irq_cmp, tio, tio_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_triple uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
        .rdata(rdata), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp),
        .tio(tio), .tio_oe(tio_oe)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2, OP_PT = 2'd3;
    localparam int NV = 53;
    // {op, addr, wdata/count, expected, tag}
    localparam logic [69:0] VEC [NV] = '{
        {OP_RD, 4'h0, 24'h0, 24'h000000, "R1"},
        {OP_RD, 4'h2, 24'h0, 24'h000000, "R1"},
        {OP_RD, 4'hD, 24'h0, 24'h000000, "R1"},
        {OP_PT, 4'h0, 24'h0, 24'h000000, "R9"},
        {OP_WR, 4'h0, 24'h000001, 24'h0, "--"},
        {OP_WT, 4'h0, 24'd9,      24'h0, "--"},
        {OP_WR, 4'h0, 24'h000000, 24'h0, "--"},
        {OP_RD, 4'h2, 24'h0, 24'h00000A, "R2"},
        {OP_WT, 4'h0, 24'd3,      24'h0, "--"},
        {OP_RD, 4'h2, 24'h0, 24'h00000A, "R3"},
        {OP_WR, 4'h0, 24'hFFFF00, 24'h0, "--"},
        {OP_RD, 4'h0, 24'h0, 24'h000000, "R8"},
        {OP_WR, 4'hC, 24'hE00004, 24'h0, "--"},
        {OP_RD, 4'hC, 24'h0, 24'h000004, "R8"},
        {OP_RD, 4'hD, 24'h0, 24'h000001, "R4"},
        {OP_WR, 4'h4, 24'h000009, 24'h0, "--"},
        {OP_WT, 4'h0, 24'd12,     24'h0, "--"},
        {OP_WR, 4'h4, 24'h000008, 24'h0, "--"},
        {OP_RD, 4'h6, 24'h0, 24'h000003, "R4"},
        {OP_RD, 4'h4, 24'h0, 24'h000008, "R4"},
        {OP_WR, 4'h8, 24'h000003, 24'h0, "--"},
        {OP_WR, 4'hA, 24'hFFFFFD, 24'h0, "--"},
        {OP_WT, 4'h0, 24'd3,      24'h0, "--"},
        {OP_PT, 4'h0, 24'h0, 24'h000E04, "R5"},
        {OP_WR, 4'h8, 24'h000002, 24'h0, "--"},
        {OP_RD, 4'hA, 24'h0, 24'h000002, "R5"},
        {OP_RD, 4'h8, 24'h0, 24'h001002, "R5"},
        {OP_WR, 4'h8, 24'h001002, 24'h0, "--"},
        {OP_RD, 4'h8, 24'h0, 24'h000002, "R7"},
        {OP_PT, 4'h0, 24'h0, 24'h000000, "R9"},
        {OP_WR, 4'h1, 24'h000005, 24'h0, "--"},
        {OP_WR, 4'h0, 24'h000015, 24'h0, "--"},
        {OP_WT, 4'h0, 24'd5,      24'h0, "--"},
        {OP_PT, 4'h0, 24'h0, 24'h000E48, "R6"},
        {OP_WR, 4'h2, 24'h000003, 24'h0, "--"},
        {OP_WT, 4'h0, 24'd1,      24'h0, "--"},
        {OP_WR, 4'h0, 24'h002015, 24'h0, "--"},
        {OP_WR, 4'h0, 24'h000014, 24'h0, "--"},
        {OP_RD, 4'h0, 24'h0, 24'h002014, "R7"},
        {OP_PT, 4'h0, 24'h0, 24'h000008, "R6"},
        {OP_WR, 4'h0, 24'h002014, 24'h0, "--"},
        {OP_RD, 4'h0, 24'h0, 24'h000014, "R7"},
        {OP_WR, 4'h4, 24'h000001, 24'h0, "--"},
        {OP_WT, 4'h0, 24'd4,      24'h0, "--"},
        {OP_WR, 4'h4, 24'h000001, 24'h0, "--"},
        {OP_WR, 4'h4, 24'h000000, 24'h0, "--"},
        {OP_RD, 4'h6, 24'h0, 24'h000006, "R2"},
        {OP_WR, 4'h4, 24'h000001, 24'h0, "--"},
        {OP_WR, 4'h4, 24'h000000, 24'h0, "--"},
        {OP_RD, 4'h6, 24'h0, 24'h000001, "R2"},
        {OP_RD, 4'h3, 24'h0, 24'h000000, "R8"},
        {OP_WR, 4'hD, 24'h00FFFF, 24'h0, "--"},
        {OP_RD, 4'hF, 24'h0, 24'h000000, "R8"}
    };

    function automatic logic [23:0] stat();
        return {12'h0, tio_oe, tio, irq_cmp, irq_ovf};
    endfunction

    task automatic chk(input logic [15:0] tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [23:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic do_rd(input logic [3:0] a);
        @(negedge clk); addr = a; wr = 1'b0;
        @(posedge clk); #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 200000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  a;
            logic [23:0] d, e;
            logic [15:0] tag;
            op  = VEC[i][69:68];
            a   = VEC[i][67:64];
            d   = VEC[i][63:40];
            e   = VEC[i][39:16];
            tag = VEC[i][15:0];
            case (op)
                OP_WR: do_wr(a, d);
                OP_RD: begin do_rd(a); chk(tag, rdata, e); end
                OP_WT: begin
                    @(negedge clk); wr = 1'b0;
                    repeat (d) @(posedge clk);
                    #1;
                end
                default: begin
                    @(negedge clk); wr = 1'b0;
                    @(posedge clk); #1;
                    chk(tag, stat(), e);
                end
            endcase
        end
        @(negedge clk); wr = 1'b0;

        // R1: reset in the middle of a run
        do_wr(4'h0, 24'h000003);
        do_wr(4'h1, 24'h000002);
        @(negedge clk); wr = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", stat(), 24'h0);
        chk("R1", rdata, 24'h0);
        @(negedge clk); rst_n = 1'b1;
        do_rd(4'h0); chk("R1", rdata, 24'h0);
        do_rd(4'h2); chk("R1", rdata, 24'h0);
        do_rd(4'h1); chk("R1", rdata, 24'h0);

        // R10: read latency and hold
        do_wr(4'hC, 24'h000007);
        do_rd(4'hC); chk("R10", rdata, 24'h000007);
        @(negedge clk); addr = 4'h0;
        #1 chk("R10", rdata, 24'h000007);
        @(posedge clk); #1;
        chk("R10", rdata, 24'h000000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule